// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port. It moves one byte per transfer over a single data line and drives its own shift clock on a second line. In transmit mode it drives the data line and presents the byte least significant bit first, one bit per shift-clock period. In receive mode it leaves the data line undriven and captures eight bits from it, one on each rising shift-clock edge.

All shift timing is counted in oscillator periods. The `osc_tick` input is a one-cycle enable that marks each oscillator period. Two speeds exist, and in both the high phase of the shift clock lasts two periods. The fast speed holds the clock low for two periods, giving a four-period bit. The slow speed holds it low for four periods, giving a six-period bit.

A transfer starts from an idle port with a transmit strobe, which also loads the byte, or with a receive strobe. At the end of a transfer the port raises a one-cycle done pulse and sets a sticky flag that stays set until software clears it. One oscillator period after the final rising shift-clock edge, the port releases the data line and leaves the clock high, where it idles.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, `sclk`=1, `sd_oe`=0, `busy`=0, `done`=0, `done_flag`=0 and `rx_data`=0.
- R2: When idle, `tx_start`=1 loads `tx_data`. In the same clock edge it sets `busy`=1 and `sd_oe`=1 and drives `sclk` low. Bit k of the byte (k=0 first) is on `sd_out` at the k-th rising `sclk` edge (counted from 0).
- R3: With `baud_slow`=0, `sclk` stays low for exactly 2 ticks and high for exactly 2 ticks between bits.
- R4: With `baud_slow`=1, `sclk` stays low for exactly 4 ticks and high for 2 ticks. `baud_slow` is captured at the start, and later changes have no effect on a transfer in progress.
- R5: `sd_out` changes only when `sclk` falls, so each bit is stable for the whole low phase before its rising edge.
- R6: On the first tick after the 8th rising edge, `sd_oe` goes to 0, `busy` goes to 0 and `done` pulses, while `sclk` stays 1.
- R7: When idle, `rx_start`=1 starts a receive. `sd_oe` stays 0, `sd_in` is sampled at each rising `sclk` edge, the first sample goes to bit 0, and `rx_data` holds the byte from the done pulse on.
- R8: `done` is high for exactly one clock. `done_flag` is set with it and stays set until `flag_clr`=1. If `flag_clr` is high in the same cycle as the end of a transfer, the set takes priority.
- R9: Start strobes while `busy`=1 are ignored. The byte in progress is unchanged and no second transfer follows.
- R10: If `tx_start` and `rx_start` are high in the same idle cycle, a transmit is performed.
- R11: Clock cycles with `osc_tick`=0 do not advance the shift timing, so `sclk` and `sd_out` hold.
- R12: `sclk` is high whenever the port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| osc_tick | input | 1 | one oscillator period elapsed |
| baud_slow | input | 1 | 0: four-period bit, 1: six-period bit |
| tx_data | input | 8 | byte to transmit |
| tx_start | input | 1 | load byte and start transmit |
| rx_start | input | 1 | start receive |
| flag_clr | input | 1 | clear the sticky done flag |
| sd_in | input | 1 | data line input |
| sd_out | output | 1 | data line output value |
| sd_oe | output | 1 | data line output enable (0 = released) |
| sclk | output | 1 | shift clock |
| busy | output | 1 | transfer in progress |
| done | output | 1 | one-cycle end-of-transfer pulse |
| done_flag | output | 1 | sticky end-of-transfer flag |
| rx_data | output | 8 | last received byte |

## Verification
The hardest cases to reach from the ports are the two boundary moments of a transfer: a start strobe that arrives in the middle of a transfer, and a flag clear that lands in the same cycle as the end of a transfer. The bench fires a second pair of start strobes with a different byte a few cycles into a running transfer. It holds `flag_clr` high across a whole transfer so that the collision with the set cannot be missed. Random tick gaps and a long run with no ticks stretch every phase. A monitor counts ticks per `sclk` phase and checks the line at each edge against the captured speed.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
    parameter int BITS       = 8,
    parameter int LOW_FAST   = 2,
    parameter int LOW_SLOW   = 4,
    parameter int HIGH_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic slow,
    input  logic run,
    output logic sclk,
    output logic rise_ev,
    output logic fall_ev,
    output logic end_ev
);
    localparam int MAXPH = (LOW_SLOW > HIGH_TICKS) ? LOW_SLOW : HIGH_TICKS;
    localparam int CW    = (MAXPH > 1) ? $clog2(MAXPH) : 1;
    localparam int BW    = (BITS > 1) ? $clog2(BITS) : 1;

    typedef struct packed {
        logic          sclk;
        logic          slow;
        logic [CW-1:0] cnt;
        logic [BW-1:0] bitn;
    } clk_st_t;

    clk_st_t q, d;
    logic [CW-1:0] low_lim;

    always_comb begin
        d       = q;
        rise_ev = 1'b0;
        fall_ev = 1'b0;
        end_ev  = 1'b0;
        low_lim = q.slow ? CW'(LOW_SLOW - 1) : CW'(LOW_FAST - 1);
        if (start) begin
            d.sclk = 1'b0;
            d.slow = slow;
            d.cnt  = '0;
            d.bitn = '0;
        end else if (run && tick) begin
            if (!q.sclk) begin
                if (q.cnt == low_lim) begin
                    d.sclk  = 1'b1;
                    d.cnt   = '0;
                    rise_ev = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end else if (q.bitn == BW'(BITS - 1)) begin
                end_ev = 1'b1;
            end else if (q.cnt == CW'(HIGH_TICKS - 1)) begin
                d.sclk  = 1'b0;
                d.cnt   = '0;
                d.bitn  = q.bitn + 1'b1;
                fall_ev = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sclk: 1'b1, slow: 1'b0, cnt: '0, bitn: '0};
        end else begin
            q <= d;
        end
    end

    assign sclk = q.sclk;

    // R12: clock parks high whenever no transfer runs
    a_r12_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> q.sclk);
    // R11: no tick, no movement of the shift clock
    a_r11_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        run && !tick && !start |=> $stable(q.sclk));
    // R2: at most one timing event per cycle
    a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_ev, fall_ev, end_ev}));
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_tx,
    input  logic            load_rx,
    input  logic [BITS-1:0] tx_data,
    input  logic            rx_mode,
    input  logic            rise_ev,
    input  logic            fall_ev,
    input  logic            end_ev,
    input  logic            sd_in,
    output logic            sd_out,
    output logic [BITS-1:0] rx_data
);
    typedef struct packed {
        logic [BITS-1:0] shreg;
        logic [BITS-1:0] rxd;
    } sh_st_t;

    sh_st_t q, d;

    always_comb begin
        d = q;
        if (load_tx) begin
            d.shreg = tx_data;
        end else if (load_rx) begin
            d.shreg = '0;
        end else if (rx_mode && rise_ev) begin
            d.shreg = {sd_in, q.shreg[BITS-1:1]};
        end else if (!rx_mode && fall_ev) begin
            d.shreg = {1'b0, q.shreg[BITS-1:1]};
        end
        if (rx_mode && end_ev) begin
            d.rxd = q.shreg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sd_out  = q.shreg[0];
    assign rx_data = q.rxd;

    // R5: transmit data moves only on a falling shift-clock event
    a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_mode && !fall_ev && !load_tx && !load_rx |=> $stable(sd_out));
    // R7: received byte updates only at the end of a transfer
    a_r7_rx_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !end_ev |=> $stable(rx_data));
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
    parameter int DATA_W     = 8,
    parameter int LOW_FAST   = 2,
    parameter int LOW_SLOW   = 4,
    parameter int HIGH_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              baud_slow,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_start,
    input  logic              rx_start,
    input  logic              flag_clr,
    input  logic              sd_in,
    output logic              sd_out,
    output logic              sd_oe,
    output logic              sclk,
    output logic              busy,
    output logic              done,
    output logic              done_flag,
    output logic [DATA_W-1:0] rx_data
);
    import ssp_pkg::*;

    typedef struct packed {
        logic      busy;
        xfer_dir_e dir;
        logic      oe;
        logic      done;
        logic      flag;
    } ctl_st_t;

    ctl_st_t q, d;
    logic start_tx, start_rx;
    logic rise_ev, fall_ev, end_ev;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        start_tx = !q.busy && tx_start;
        start_rx = !q.busy && !tx_start && rx_start;
        if (flag_clr) begin
            d.flag = 1'b0;
        end
        if (start_tx) begin
            d.busy = 1'b1;
            d.dir  = DIR_TX;
            d.oe   = 1'b1;
        end else if (start_rx) begin
            d.busy = 1'b1;
            d.dir  = DIR_RX;
            d.oe   = 1'b0;
        end else if (end_ev) begin
            d.busy = 1'b0;
            d.oe   = 1'b0;
            d.done = 1'b1;
            d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, dir: DIR_TX, oe: 1'b0, done: 1'b0, flag: 1'b0};
        end else begin
            q <= d;
        end
    end

    ssp_clkgen #(
        .BITS      (DATA_W),
        .LOW_FAST  (LOW_FAST),
        .LOW_SLOW  (LOW_SLOW),
        .HIGH_TICKS(HIGH_TICKS)
    ) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (osc_tick),
        .start  (start_tx | start_rx),
        .slow   (baud_slow),
        .run    (q.busy),
        .sclk   (sclk),
        .rise_ev(rise_ev),
        .fall_ev(fall_ev),
        .end_ev (end_ev)
    );

    ssp_shifter #(
        .BITS(DATA_W)
    ) u_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_tx(start_tx),
        .load_rx(start_rx),
        .tx_data(tx_data),
        .rx_mode(q.dir == DIR_RX),
        .rise_ev(rise_ev),
        .fall_ev(fall_ev),
        .end_ev (end_ev),
        .sd_in  (sd_in),
        .sd_out (sd_out),
        .rx_data(rx_data)
    );

    assign sd_oe     = q.oe;
    assign busy      = q.busy;
    assign done      = q.done;
    assign done_flag = q.flag;

    // R9: a running transfer is never cut short by new strobes
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy && !end_ev |=> q.busy);
    // R6: the line is released with the clock high and the done pulse
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.oe) |-> sclk && q.done);
    // R8: done lasts exactly one cycle and always sets the flag
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> q.flag);
    // R7: receive never drives the line
    a_r7_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy && q.dir == DIR_RX |-> !q.oe);
endmodule

// File: tb/sync_shift_port_tb.sv
module sync_shift_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b1;
    logic       baud_slow = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_start = 1'b0;
    logic       rx_start = 1'b0;
    logic       flag_clr = 1'b0;
    logic       sd_in;
    logic       sd_out, sd_oe, sclk, busy, done, done_flag;
    logic [7:0] rx_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int tick_mode = 0;

    bit       x_rx;
    bit       x_slow;
    bit [7:0] x_byte;
    bit [7:0] rx_pat;
    bit       mon_en = 0;
    bit       in_x = 0;
    bit       chk_after = 0;
    bit       last_sclk = 1, last_busy = 0, t_prev = 0;
    int       rise_num = 0, low_cnt = 0, high_cnt = 0, done_seen = 0;

    sync_shift_port u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .baud_slow(baud_slow),
        .tx_data(tx_data), .tx_start(tx_start), .rx_start(rx_start),
        .flag_clr(flag_clr), .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe),
        .sclk(sclk), .busy(busy), .done(done), .done_flag(done_flag),
        .rx_data(rx_data)
    );

    always #2.5 clk = ~clk;

    assign sd_in = (rise_num < 8) ? rx_pat[rise_num[2:0]] : 1'b0;

    function automatic int exp_low(bit s);
        return s ? 4 : 2;
    endfunction

    function automatic bit exp_bit(bit [7:0] b, int k);
        return b[k[2:0]];
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    always @(posedge clk) begin
        #2;
        case (tick_mode)
            0:       osc_tick = 1'b1;
            1:       osc_tick = ($urandom_range(0, 2) != 0);
            default: osc_tick = 1'b0;
        endcase
    end

    // edge monitor: counts ticks per shift-clock phase and checks the line
    always @(negedge clk) begin
        bit ticked;
        ticked = t_prev;
        t_prev = osc_tick;
        if (mon_en) begin
            if (chk_after) begin
                chk(done == 1'b0, "R8 done one cycle", done, 0);
                chk(sclk == 1'b1 && busy == 1'b0, "R12 idle high", sclk, 1);
                chk_after = 0;
            end
            if (busy && !last_busy) begin
                in_x = 1; rise_num = 0; low_cnt = 0; high_cnt = 0;
                chk(sclk == 1'b0, "R2 sclk low at start", sclk, 0);
                chk(sd_oe == !x_rx, "R2/R7 drive at start", sd_oe, !x_rx);
                if (!x_rx) chk(sd_out == x_byte[0], "R2 first bit", sd_out, x_byte[0]);
            end else if (in_x) begin
                if (ticked) begin
                    if (!last_sclk) low_cnt++;
                    else high_cnt++;
                end
                if (sclk && !last_sclk) begin
                    chk(low_cnt == exp_low(x_slow), x_slow ? "R4 low length" : "R3 low length",
                        low_cnt, exp_low(x_slow));
                    chk(busy == 1'b1, "R9 busy in transfer", busy, 1);
                    chk(sd_oe == !x_rx, "R7 line drive", sd_oe, !x_rx);
                    if (!x_rx)
                        chk(sd_out == exp_bit(x_byte, rise_num), "R2 bit at rise",
                            sd_out, exp_bit(x_byte, rise_num));
                    rise_num++;
                    high_cnt = 0;
                end else if (!sclk && last_sclk) begin
                    chk(high_cnt == 2, x_slow ? "R4 high length" : "R3 high length", high_cnt, 2);
                    low_cnt = 0;
                    if (!x_rx)
                        chk(sd_out == exp_bit(x_byte, rise_num), "R5 bit at fall",
                            sd_out, exp_bit(x_byte, rise_num));
                end else if (rise_num == 8 && high_cnt == 1) begin
                    chk(sd_oe == 1'b0, "R6 release", sd_oe, 0);
                    chk(busy == 1'b0 && done == 1'b1, "R6 done at end", done, 1);
                    chk(sclk == 1'b1, "R6 clock high", sclk, 1);
                    chk(done_flag == 1'b1, "R8 flag set", done_flag, 1);
                    if (x_rx) chk(rx_data == rx_pat, "R7 rx byte", rx_data, rx_pat);
                    in_x = 0;
                    chk_after = 1;
                    done_seen++;
                end else if (rise_num == 8) begin
                    chk(sd_oe == !x_rx && busy == 1'b1, "R6 hold until tick", sd_oe, !x_rx);
                end else if (!x_rx && !sclk) begin
                    chk(sd_out == exp_bit(x_byte, rise_num), "R5 bit stable",
                        sd_out, exp_bit(x_byte, rise_num));
                end
            end
        end
        last_sclk = sclk;
        last_busy = busy;
    end

    task automatic xfer(bit rx, bit [7:0] b, bit slow, bit both, bit intrude, bit stall);
        int target;
        @(posedge clk); #1;
        x_rx = rx && !both; x_byte = b; x_slow = slow; rx_pat = b;
        tx_data = b; baud_slow = slow;
        tx_start = !rx || both; rx_start = rx || both;
        target = done_seen + 1;
        @(posedge clk); #1;
        tx_start = 0; rx_start = 0;
        baud_slow = $urandom_range(0, 1);
        tx_data = ~b;
        if (stall) begin
            int save;
            logic s0, o0;
            save = tick_mode;
            tick_mode = 2;
            @(negedge clk);
            @(negedge clk);
            s0 = sclk; o0 = sd_out;
            repeat (20) @(negedge clk);
            chk(sclk == s0 && sd_out == o0, "R11 hold without tick", {sclk, sd_out}, {s0, o0});
            @(posedge clk); #1;
            tick_mode = save;
        end
        if (intrude) begin
            repeat (5) @(posedge clk);
            #1; tx_data = ~b; tx_start = 1; rx_start = 1;
            @(posedge clk); #1; tx_start = 0; rx_start = 0;
        end
        wait (done_seen >= target);
        if (intrude) begin
            repeat (10) @(negedge clk);
            chk(busy == 1'b0, "R9 no second transfer", busy, 0);
        end
        repeat (2) @(posedge clk);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(sclk == 1 && sd_oe == 0 && busy == 0, "R1 reset lines", {sclk, sd_oe, busy}, 3'b100);
        chk(done == 0 && done_flag == 0, "R1 reset flags", {done, done_flag}, 0);
        chk(rx_data == 8'h00, "R1 reset rx_data", rx_data, 0);
        mon_en = 1;

        xfer(0, 8'hA5, 0, 0, 0, 0);                 // R2 R3 fast transmit
        xfer(0, 8'h3C, 1, 0, 0, 0);                 // R4 slow transmit
        xfer(1, 8'h96, 0, 0, 0, 0);                 // R7 receive
        xfer(1, 8'h01, 1, 0, 0, 0);                 // R7 slow receive
        repeat (3) @(negedge clk);
        chk(done_flag == 1, "R8 flag sticky", done_flag, 1);
        @(posedge clk); #1 flag_clr = 1;
        @(posedge clk); #1 flag_clr = 0;
        @(negedge clk);
        chk(done_flag == 0, "R8 flag cleared", done_flag, 0);

        @(posedge clk); #1 flag_clr = 1;            // R8 set beats clear
        xfer(0, 8'h80, 0, 0, 0, 0);
        @(negedge clk);
        chk(done_flag == 0, "R8 clear after set", done_flag, 0);
        @(posedge clk); #1 flag_clr = 0;

        xfer(0, 8'hC3, 0, 0, 1, 0);                 // R9 strobes while busy
        xfer(1, 8'h5A, 1, 1, 0, 0);                 // R10 both strobes
        xfer(0, 8'hF0, 1, 0, 0, 1);                 // R11 stall
        tick_mode = 1;
        for (int i = 0; i < 40; i++) begin
            bit [7:0] b;
            b = 8'($urandom);
            xfer($urandom_range(0, 1), b, $urandom_range(0, 1), 0, (i % 9) == 4, 0);
        end
        tick_mode = 0;
        xfer(0, 8'hFF, 0, 0, 0, 0);
        xfer(1, 8'h00, 0, 0, 0, 0);
        finish_run();
    end
endmodule